// File: doc/BRIEF.md
# Status Edge Interrupt Unit

This block sits beside a serial-interface controller. It turns the controller's level status flags into a single interrupt request. Typical flags are transfer complete, interface idle-and-ready, FIFO service-ready, FIFO empty and FIFO full.

Each flag has its own rising-edge detector. A detected edge sets a sticky cause bit, and software clears a cause bit by writing a one to it. A per-bit enable mask decides which pending causes can reach the interrupt line, and that line is driven from a flop. A flag that is already high causes no event. Software must therefore read the live level copy before waiting on an interrupt.

The status flags come from logic in the same clock domain. Producing those flags is outside this block.

Top module: `irqsu_top`

## Requirements
- R1: A 0-to-1 change on `status_i[k]` sets `cause_o[k]` on the next clock edge. The bit reads high one cycle after the status bit rises.
- R2: A status bit that stays high sets no further cause. Once its cause bit is cleared, it stays clear for as long as the status holds high.
- R3: A status bit that is already high when reset is released sets no cause bit.
- R4: A cycle with `clr_we`=1 clears exactly the cause bits where `clr_bits` holds a 1. The other cause bits are unchanged.
- R5: A rising edge and a clear can hit the same bit in the same cycle. In that case the bit ends up set.
- R6: `mask_we`=1 loads `mask_bits` into `mask_o` on the next edge. While `mask_o` is all zeros, `irq_o` stays low, whatever the causes hold.
- R7: `irq_o` is a registered copy of the OR over (`cause_o` AND `mask_o`). It rises one cycle after a masked-in cause appears, and it falls one cycle after the last one clears.
- R8: Cause bits keep latching edges while they are masked out. Enabling a pending cause drives `irq_o` high one cycle after `mask_o` updates.
- R9: `level_o` shows the status flags one cycle late, at the same bit positions as the causes. Bit 0 means transfer done and bit 1 means transfer ready.
- R10: In reset, and right after it, `cause_o`, `mask_o` and `irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| status_i | input | NSRC | Level status flags from the controller |
| clr_we | input | 1 | Write strobe for the write-one-to-clear of the causes |
| clr_bits | input | NSRC | Cause bits to clear (1 = clear) |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_bits | input | NSRC | New enable mask value |
| level_o | output | NSRC | Registered live status copy |
| cause_o | output | NSRC | Sticky cause bits |
| mask_o | output | NSRC | Current enable mask |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Faults in the edge-history register show up in two ways. A held-high flag can raise a second cause after it is cleared. A flag that was high at reset can raise a cause. Either fault is visible on `cause_o` one cycle after the stimulus.

A wrong merge of clear and set priority shows in `cause_o` right after a same-cycle edge and clear. A wrong interrupt path shows as `irq_o` being early, late or stuck. The bench checks each of these at the exact cycle named by R1, R5, R7 and R8.

// File: rtl/irqsu_pkg.sv
package irqsu_pkg;
  localparam int unsigned NSRC_DEF = 8;
  localparam int unsigned BIT_XFER_DONE = 0;
  localparam int unsigned BIT_XFER_RDY  = 1;

  function automatic logic [NSRC_DEF-1:0] rise_of(
      input logic [NSRC_DEF-1:0] now_v, input logic [NSRC_DEF-1:0] was_v);
    return now_v & ~was_v;
  endfunction

  function automatic logic [NSRC_DEF-1:0] cause_step(
      input logic [NSRC_DEF-1:0] held, input logic [NSRC_DEF-1:0] rise,
      input logic [NSRC_DEF-1:0] wipe);
    return (held & ~wipe) | rise;
  endfunction
endpackage

// File: rtl/irqsu_edge_det.sv
module irqsu_edge_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] hist_o,
  output logic [W-1:0] rise_o
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic hist_q;
      // history resets high so a flag already high at reset release is no edge
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= 1'b1;
        else        hist_q <= lvl_i[g];
      end
      assign hist_o[g] = hist_q;
      assign rise_o[g] = lvl_i[g] & ~hist_q;
    end
  endgenerate
endmodule

// File: rtl/irqsu_cause_bank.sv
module irqsu_cause_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] wipe_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] cause_q;
  logic [W-1:0] cause_d;

  always_comb begin
    cause_d = (cause_q & ~wipe_i) | rise_i;  // a new edge wins over a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/irqsu_irq_gate.sv
module irqsu_irq_gate #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic [W-1:0] mask_bits,
  input  logic [W-1:0] cause_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] mask_q;
  logic         irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_bits;
  end

  assign pend_o = cause_i & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend_o;
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/irqsu_top.sv
module irqsu_top #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] status_i,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_bits,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_bits,
  output logic [NSRC-1:0] level_o,
  output logic [NSRC-1:0] cause_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);
  logic [NSRC-1:0] hist_w;
  logic [NSRC-1:0] rise_w;
  logic [NSRC-1:0] wipe_w;
  logic [NSRC-1:0] pend_w;

  assign wipe_w = clr_bits & {NSRC{clr_we}};

  irqsu_edge_det #(.W(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(status_i),
    .hist_o(hist_w), .rise_o(rise_w)
  );

  irqsu_cause_bank #(.W(NSRC)) u_cause (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_w),
    .wipe_i(wipe_w), .cause_o(cause_o)
  );

  irqsu_irq_gate #(.W(NSRC)) u_gate (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_bits(mask_bits),
    .cause_i(cause_o), .mask_o(mask_o), .pend_o(pend_w), .irq_o(irq_o)
  );

  assign level_o = hist_w;
endmodule

// File: rtl/irqsu_checker.sv
module irqsu_checker #(
  parameter int unsigned NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] status_i,
  input logic [NSRC-1:0] level_o,
  input logic [NSRC-1:0] cause_o,
  input logic [NSRC-1:0] mask_o,
  input logic            irq_o,
  input logic [NSRC-1:0] rise_w,
  input logic [NSRC-1:0] wipe_w
);
  a_r1_edge_sets_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_i & ~level_o)) |=> ((cause_o & $past(status_i & ~level_o)) == $past(status_i & ~level_o)));

  a_r4_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (|wipe_w) |=> ((cause_o & $past(wipe_w & ~rise_w)) == '0));

  a_r2_no_set_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_o & ~$past(cause_o) & ~$past(rise_w)) == '0));

  a_r7_irq_follows_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cause_o & mask_o)) |=> irq_o);

  a_r7_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(cause_o & mask_o)) |=> !irq_o);

  a_r6_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o == '0) |=> !irq_o);

  a_r9_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level_o == $past(status_i)));
endmodule

bind irqsu_top irqsu_checker #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_i(status_i), .level_o(level_o),
  .cause_o(cause_o), .mask_o(mask_o), .irq_o(irq_o),
  .rise_w(rise_w), .wipe_w(wipe_w)
);

// File: tb/irqsu_top_bench.sv
module irqsu_top_bench;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] status_i = '0;
  logic clr_we = 1'b0;
  logic [N-1:0] clr_bits = '0;
  logic mask_we = 1'b0;
  logic [N-1:0] mask_bits = '0;
  logic [N-1:0] level_o, cause_o, mask_o;
  logic irq_o;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irqsu_top #(.NSRC(N)) u_irqsu_top (
    .clk(clk), .rst_n(rst_n), .status_i(status_i), .clr_we(clr_we),
    .clr_bits(clr_bits), .mask_we(mask_we), .mask_bits(mask_bits),
    .level_o(level_o), .cause_o(cause_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_clear(input logic [N-1:0] b);
    clr_we = 1'b1; clr_bits = b; tick(); clr_we = 1'b0; clr_bits = '0;
  endtask

  task automatic do_mask(input logic [N-1:0] b);
    mask_we = 1'b1; mask_bits = b; tick(); mask_we = 1'b0;
  endtask

  task automatic t_reset();
    status_i = 8'h08;  // bit 3 already high at reset
    repeat (3) @(negedge clk);
    chk("R10 cause in reset", cause_o, '0);
    chk("R10 mask in reset", mask_o, '0);
    chk("R10 irq in reset", {7'd0, irq_o}, '0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R3 high-at-reset sets no cause", cause_o, '0);
    chk("R10 irq after reset", {7'd0, irq_o}, '0);
  endtask

  task automatic t_edge();
    status_i = 8'h09;  // bit 0 (transfer done) rises
    tick();
    chk("R1 rise sets cause bit0", cause_o, 8'h01);
    status_i = 8'h0B;  // bit 1 rises
    tick();
    chk("R1 rise sets cause bit1", cause_o, 8'h03);
    chk("R6 mask zero keeps irq low", {7'd0, irq_o}, '0);
    do_clear(8'h01);
    chk("R4 clear only written bit", cause_o, 8'h02);
    do_clear(8'h02);
    chk("R4 clear second bit", cause_o, 8'h00);
  endtask

  task automatic t_held();
    tick(); tick();
    chk("R2 held level gives no new cause", cause_o, 8'h00);
    status_i = 8'h08;
    tick();
    chk("R2 fall sets no cause", cause_o, 8'h00);
  endtask

  task automatic t_race();
    status_i = 8'h0C; clr_we = 1'b1; clr_bits = 8'h04;
    tick();
    clr_we = 1'b0; clr_bits = '0;
    chk("R5 edge beats clear", cause_o, 8'h04);
    do_clear(8'hFF);
    chk("R4 clear all", cause_o, 8'h00);
    status_i = 8'h08;
    tick();
  endtask

  task automatic t_mask();
    status_i = 8'h18;  // bit 4 rises while masked
    tick();
    chk("R8 masked cause still latches", cause_o, 8'h10);
    tick();
    chk("R6 irq low while masked", {7'd0, irq_o}, '0);
    do_mask(8'h10);
    chk("R6 mask loaded", mask_o, 8'h10);
    chk("R8 irq not yet", {7'd0, irq_o}, '0);
    tick();
    chk("R8 unmask raises irq", {7'd0, irq_o}, 8'h01);
    do_clear(8'h10);
    chk("R7 irq lags clear", {7'd0, irq_o}, 8'h01);
    tick();
    chk("R7 irq falls", {7'd0, irq_o}, '0);
    status_i = 8'h08; tick();
    status_i = 8'h18; tick();
    chk("R7 cause set", cause_o, 8'h10);
    chk("R7 irq one cycle later", {7'd0, irq_o}, '0);
    tick();
    chk("R7 irq rises", {7'd0, irq_o}, 8'h01);
    do_mask(8'h00);
    tick();
    chk("R6 zero mask blocks irq", {7'd0, irq_o}, '0);
    chk("R6 cause kept while blocked", cause_o, 8'h10);
    do_clear(8'hFF);
  endtask

  task automatic t_level();
    status_i = 8'h3C;
    chk("R9 level before edge", level_o, 8'h18);
    tick();
    chk("R9 level after edge", level_o, 8'h3C);
    status_i = 8'h00;
    tick();
    chk("R9 level cleared", level_o, 8'h00);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_held();
    t_race();
    t_mask();
    t_level();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule